// File: doc/BRIEF.md
# Bus Yield Arbiter

This block sits on the bus-master side of a shared bus. It lets an external master take over the bus through a three-wire handshake made of an active-low request input, an active-low grant output and an active-low acknowledge input. The unit runs on a tick at twice the bus clock rate. A phase bit marks the rising and falling halves of each bus clock, so every half-clock window becomes a whole count of ticks. Both handshake inputs pass through a synchroniser before the state machine acts on them.

When a request arrives and nothing else owns the bus, the grant is asserted after a fixed number of ticks. An acknowledge negates the grant. If no bus cycle is in progress the acknowledge also turns off two groups of output enables: one for address, data and control, and one for function code and valid address. If a bus cycle is in progress, the enables go off when that cycle ends. When the acknowledge is released, the unit re-enables the function-code group first and the address/data/control group one tick later. If the requester withdraws before it acknowledges, the grant is cancelled and the unit keeps the bus.

Top module: `bus_yield_arbiter`

In the requirements below, a tick is one rising edge of `clk`. Latencies are counted from the first edge that samples the input's new level, which is tick 1.

## Requirements
- R1: While and directly after reset, `grant_n` is 1, `adc_oe` and `fcv_oe` are 1, and `bclk_phase` is 0.
- R2: `bclk_phase` changes level on every tick after reset.
- R3: When the unit is idle and no acknowledge is present, a request (`bus_req_n` low) drives `grant_n` low at tick 5.
- R4: An acknowledge (`grant_ack_n` low) arriving while the grant is asserted drives `grant_n` high at tick 3.
- R5: If the request is withdrawn while the grant is asserted and no acknowledge is present, `grant_n` goes high at tick 3, and both output enables stay 1 throughout.
- R6: A request pulse that is low for w ticks in the idle state produces a grant exactly when w is at least 3. A shorter pulse never drives `grant_n` low.
- R7: After `grant_n` rises, it stays high for at least 3 ticks.
- R8: While acknowledged, both output enables go to 0. With no bus cycle in progress, they go to 0 one tick after the grant is negated, or at tick 4 for an acknowledge that arrives while idle. While `cycle_busy` is 1 they stay 1, and they go to 0 on the first tick after it drops.
- R9: After the acknowledge is released, `fcv_oe` returns to 1 at tick 5 and `adc_oe` one tick later. `adc_oe` is never 1 while `fcv_oe` is 0.
- R10: While acknowledged, changes on `bus_req_n` never drive `grant_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n | input | 1 | Active-low bus request from an external master |
| grant_ack_n | input | 1 | Active-low grant acknowledge from the new owner |
| cycle_busy | input | 1 | High while an own bus cycle is in progress |
| grant_n | output | 1 | Active-low bus grant |
| adc_oe | output | 1 | Output enable for the address, data and control group |
| fcv_oe | output | 1 | Output enable for the function-code and valid-address group |
| bclk_phase | output | 1 | Half-clock phase bit, 0 in the rising half |

## Verification
The bench runs a fixed-seed random mix of four handshake shapes, each one probing a different path:
- A full grant, acknowledge and release, with and without a bus cycle in progress. This separates grant, yield-delay and reclaim timing.
- A grant followed by a withdrawn request. This separates cancellation from yield.
- Request pulses of random width. These find the exact shortest width that still earns a grant.
- An acknowledge with no grant. This shows that the enables are governed by the acknowledge alone.

Request toggles during acknowledge show that the grant cannot reappear, and a monitor measures every high stretch of the grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [2:0] {
      ST_OWN     = 3'd0,
      ST_PEND    = 3'd1,
      ST_GRANT   = 3'd2,
      ST_YIELD   = 3'd3,
      ST_RECLAIM = 3'd4
   } arb_state_e;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] pipe;

   if (STAGES < 2) begin : g_bad_stages
      $error("arb_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/arb_phase.sv
module arb_phase (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= 1'b0;
      else        phase <= ~phase;
   end

   AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (phase != $past(phase))); // R2
endmodule

// File: rtl/arb_reclaim.sv
module arb_reclaim #(
   parameter int FCV_TICKS = 2,
   parameter int ADC_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic drop,
   output logic adc_oe,
   output logic fcv_oe,
   output logic finish
);
   localparam int CW = $clog2(ADC_TICKS + 1);

   logic          running;
   logic [CW-1:0] rc;

   if (FCV_TICKS < 2 || ADC_TICKS <= FCV_TICKS) begin : g_bad_gap
      $error("arb_reclaim needs FCV_TICKS >= 2 and ADC_TICKS > FCV_TICKS");
   end

   assign finish = running && ((rc + 1'b1) == CW'(ADC_TICKS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         rc      <= '0;
         adc_oe  <= 1'b1;
         fcv_oe  <= 1'b1;
      end else begin
         if (drop) begin
            adc_oe <= 1'b0;
            fcv_oe <= 1'b0;
         end
         if (start) begin
            running <= 1'b1;
            rc      <= '0;
         end else if (running) begin
            rc <= rc + 1'b1;
            if ((rc + 1'b1) == CW'(FCV_TICKS)) fcv_oe <= 1'b1;
            if (finish) begin
               adc_oe  <= 1'b1;
               running <= 1'b0;
            end
         end
      end
   end

   AST_OE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      adc_oe |-> fcv_oe); // R9
endmodule

// File: rtl/bus_yield_arbiter.sv
module bus_yield_arbiter
   import arb_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int GRANT_TICKS = 5,
   parameter int FCV_TICKS   = 2,
   parameter int ADC_TICKS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_req_n,
   input  logic grant_ack_n,
   input  logic cycle_busy,
   output logic grant_n,
   output logic adc_oe,
   output logic fcv_oe,
   output logic bclk_phase
);
   localparam int PEND_LOAD = GRANT_TICKS - SYNC_STAGES - 2;
   localparam int CNT_W     = $clog2(GRANT_TICKS + 1);

   if (GRANT_TICKS < SYNC_STAGES + 2 || GRANT_TICKS > 7) begin : g_bad_grant
      $error("GRANT_TICKS must lie in SYNC_STAGES+2 .. 7");
   end
   if (SYNC_STAGES + 1 < 3 || SYNC_STAGES + 1 > 7) begin : g_bad_sync
      $error("acknowledge latency SYNC_STAGES+1 must lie in 3 .. 7");
   end

   arb_state_e       state, nxt;
   logic [CNT_W-1:0] cnt;
   logic [1:0]       sync_q;
   logic             req_s, ack_s;
   logic             go_reclaim, drop, grant_set, grant_clr, finish;

   arb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({~grant_ack_n, ~bus_req_n}),
      .q    (sync_q)
   );
   assign req_s = sync_q[0];
   assign ack_s = sync_q[1];

   arb_phase u_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .phase(bclk_phase)
   );

   arb_reclaim #(.FCV_TICKS(FCV_TICKS), .ADC_TICKS(ADC_TICKS)) u_reclaim (
      .clk   (clk),
      .rst_n (rst_n),
      .start (go_reclaim),
      .drop  (drop),
      .adc_oe(adc_oe),
      .fcv_oe(fcv_oe),
      .finish(finish)
   );

   always_comb begin
      nxt        = state;
      go_reclaim = 1'b0;
      drop       = 1'b0;
      grant_set  = 1'b0;
      grant_clr  = 1'b0;
      unique case (state)
         ST_OWN: begin
            if (ack_s)      nxt = ST_YIELD;
            else if (req_s) nxt = ST_PEND;
         end
         ST_PEND: begin
            if (ack_s)           nxt = ST_YIELD;
            else if (!req_s)     nxt = ST_OWN;
            else if (cnt == '0) begin
               nxt       = ST_GRANT;
               grant_set = 1'b1;
            end
         end
         ST_GRANT: begin
            if (ack_s) begin
               nxt       = ST_YIELD;
               grant_clr = 1'b1;
            end else if (!req_s) begin
               nxt        = ST_RECLAIM;
               grant_clr  = 1'b1;
               go_reclaim = 1'b1;
            end
         end
         ST_YIELD: begin
            if (!ack_s) begin
               nxt        = ST_RECLAIM;
               go_reclaim = 1'b1;
            end else if (!cycle_busy) begin
               drop = 1'b1;
            end
         end
         ST_RECLAIM: begin
            if (finish) nxt = ST_OWN;
         end
         default: nxt = ST_OWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_OWN;
         cnt     <= CNT_W'(PEND_LOAD);
         grant_n <= 1'b1;
      end else begin
         state <= nxt;
         if (state != ST_PEND)  cnt <= CNT_W'(PEND_LOAD);
         else if (cnt != '0)    cnt <= cnt - 1'b1;
         if (grant_set)         grant_n <= 1'b0;
         else if (grant_clr)    grant_n <= 1'b1;
      end
   end

   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grant_n) |-> $past(req_s)); // R3
   AST_ACK_HOLDS_GRANT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_s && $past(ack_s)) |-> grant_n); // R10
   AST_GRANT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_n) |=> (grant_n ##1 grant_n)); // R7
   AST_OE_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fcv_oe) |-> $past(ack_s && !cycle_busy)); // R8
endmodule

// File: tb/bus_yield_arbiter_bench.sv
`timescale 1ns/1ps
module bus_yield_arbiter_bench;
   logic clk = 1'b0;
   logic rst_n, bus_req_n, grant_ack_n, cycle_busy;
   logic grant_n, adc_oe, fcv_oe, bclk_phase;
   int   checks = 0;
   int   errors = 0;

   always #10 clk = ~clk;

   bus_yield_arbiter u_bus_yield_arbiter (
      .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .grant_ack_n(grant_ack_n),
      .cycle_busy(cycle_busy), .grant_n(grant_n), .adc_oe(adc_oe),
      .fcv_oe(fcv_oe), .bclk_phase(bclk_phase)
   );

   function automatic int exp_grant_lat();  return 5; endfunction
   function automatic int exp_ack_lat();    return 3; endfunction
   function automatic int exp_cancel_lat(); return 3; endfunction
   function automatic int exp_idle_drop();  return 4; endfunction
   function automatic int exp_fcv_back();   return 5; endfunction
   function automatic bit exp_pulse_grants(int w); return w >= 3; endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit hit(int sel);
      case (sel)
         0: return grant_n == 1'b0;
         1: return grant_n == 1'b1;
         2: return fcv_oe == 1'b1;
         3: return adc_oe == 1'b1;
         default: return adc_oe == 1'b0;
      endcase
   endfunction

   task automatic measure(input int sel, output int n);
      n = 0;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end while (!hit(sel) && n < 20);
      if (!hit(sel)) n = -1;
   endtask

   // R7 monitor: width of every high stretch of grant_n
   int hi_w = 0;
   always @(negedge clk) begin
      if (!rst_n) hi_w <= 0;
      else if (grant_n) hi_w <= hi_w + 1;
      else begin
         if (hi_w != 0) chk("R7 grant high width>=3", (hi_w >= 3) ? 1 : 0, 1);
         hi_w <= 0;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic scen_full(input bit busy, input int pre, input int hold);
      int n;
      int stayed;
      int seen;
      @(negedge clk); bus_req_n = 1'b0;
      measure(0, n); chk("R3 grant latency", n, exp_grant_lat());
      repeat (pre) @(negedge clk);
      grant_ack_n = 1'b0; cycle_busy = busy;
      measure(1, n); chk("R4 ack to grant negate", n, exp_ack_lat());
      if (busy) begin
         stayed = 1;
         for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (!adc_oe || !fcv_oe) stayed = 0;
         end
         chk("R8 enables held during busy cycle", stayed, 1);
         cycle_busy = 1'b0;
      end
      measure(4, n); chk("R8 enable drop latency", n, 1);
      chk("R8 fcv off with adc", fcv_oe, 0);
      bus_req_n = 1'b1;
      seen = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i == 2) bus_req_n = 1'b0;
         if (i == 4) bus_req_n = 1'b1;
         if (!grant_n) seen = 1;
      end
      chk("R10 no grant while acknowledged", seen, 0);
      grant_ack_n = 1'b1;
      measure(2, n); chk("R9 fcv re-enable latency", n, exp_fcv_back());
      measure(3, n); chk("R9 adc follows fcv", n, 1);
      repeat (4) @(negedge clk);
   endtask

   task automatic scen_cancel(input int pre);
      int n;
      @(negedge clk); bus_req_n = 1'b0;
      measure(0, n); chk("R3 grant latency", n, exp_grant_lat());
      repeat (pre) @(negedge clk);
      bus_req_n = 1'b1;
      measure(1, n); chk("R5 cancel latency", n, exp_cancel_lat());
      chk("R5 enables stay on", {30'd0, adc_oe, fcv_oe}, 3);
      repeat (8) @(negedge clk);
      chk("R5 enables on after reclaim", {30'd0, adc_oe, fcv_oe}, 3);
   endtask

   task automatic scen_pulse(input int w);
      int seen = 0;
      @(negedge clk); bus_req_n = 1'b0;
      for (int i = 1; i <= 16; i++) begin
         @(negedge clk);
         if (i == w) bus_req_n = 1'b1;
         if (!grant_n) seen = 1;
      end
      chk($sformatf("R6 pulse width %0d grants", w), seen, exp_pulse_grants(w));
      repeat (6) @(negedge clk);
   endtask

   task automatic scen_idle_ack();
      int n;
      @(negedge clk); grant_ack_n = 1'b0;
      measure(4, n); chk("R8 idle acknowledge drop latency", n, exp_idle_drop());
      chk("R8 grant stays off", grant_n, 1);
      grant_ack_n = 1'b1;
      measure(2, n); chk("R9 fcv re-enable latency", n, exp_fcv_back());
      measure(3, n); chk("R9 adc follows fcv", n, 1);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      int ph;
      int tog;
      void'($urandom(32'd1297));
      rst_n = 1'b0; bus_req_n = 1'b1; grant_ack_n = 1'b1; cycle_busy = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset grant_n", grant_n, 1);
      chk("R1 reset enables", {30'd0, adc_oe, fcv_oe}, 3);
      chk("R1 reset phase", bclk_phase, 0);
      rst_n = 1'b1;
      ph  = bclk_phase;
      tog = 1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (bclk_phase == ph) tog = 0;
         ph = bclk_phase;
      end
      chk("R2 phase toggles each tick", tog, 1);
      repeat (2) @(negedge clk);
      // directed corners
      scen_full(1'b0, 0, 0);
      scen_full(1'b1, 0, 5);
      scen_cancel(0);
      scen_pulse(2);
      scen_pulse(3);
      scen_idle_ack();
      // constrained random mix
      for (int k = 0; k < 40; k++) begin
         case ($urandom_range(0, 3))
            0: scen_full($urandom_range(0, 1) == 1, $urandom_range(0, 3), $urandom_range(1, 6));
            1: scen_cancel($urandom_range(0, 4));
            2: scen_pulse($urandom_range(1, 7));
            default: scen_idle_ack();
         endcase
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule